// File: doc/BRIEF.md
# First-Hit Channel Formatter

This block turns one accepted trigger into a frame of fixed length, whatever the detector occupancy. It has 32 channels. For each channel it looks at a programmable number of bunch crossings, one to three. It keeps only the earliest hit found and reduces it to one byte. That byte holds a 2-bit code for the crossing the hit fell in and the 6-bit drift time of that hit. A 32-bit header comes before the 32 channel bytes, so every frame is 288 bits long.

The frame is streamed out one byte per clock, over 36 cycles. At the intended 40 MHz clock every event takes exactly 900 ns to read out. The whole frame is captured on the clock edge that accepts the trigger, so the hit inputs may change while the frame is being read out. While a frame is going out, a busy flag is high and any new trigger is dropped.

Top module: `fhf_formatter`

## Requirements
- R1: A frame is 36 bytes. The four header bytes come first, least significant byte first, so `header_i` bit 0 is `byte_o` bit 0 of the first byte. The channel bytes follow in channel order 0 to 31.
- R2: In each channel byte, bits [7:6] hold the crossing code and bits [5:0] hold the drift time.
- R3: Crossings are indexed 0, 1 and 2. The crossing code is 00 when the earliest examined hit is in crossing 0, 01 for crossing 1 and 10 for crossing 2. The drift time comes from that earliest hit, and later hits on the channel are discarded.
- R4: A channel with no examined hit gives code 11 and drift time 0.
- R5: `nbx_cfg_i` (1, 2 or 3) sets how many crossings are examined, starting at crossing 0. Hits in crossings at or beyond that count are ignored. The value 0 is treated as 1.
- R6: A trigger seen at a clock edge while `busy_o` is low is accepted. From that edge on, `busy_o` and `byte_valid_o` are high for exactly 36 cycles. `frame_start_o` is high only during the first of those cycles.
- R7: A trigger that arrives while `busy_o` is high is rejected. This includes the last byte cycle. A rejected trigger neither restarts nor extends the frame. Input changes after the accepting edge do not alter the frame.
- R8: After reset, `busy_o`, `byte_valid_o` and `frame_start_o` are low and `byte_o` is 0. `byte_o` stays 0 whenever `byte_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger request, sampled at a clock edge |
| nbx_cfg_i | input | 2 | Number of crossings to examine (0 is treated as 1) |
| header_i | input | 32 | Header word for the frame |
| hit_i | input | 96 | Hit flags, bit b*32+c is crossing b, channel c |
| drift_i | input | 576 | Drift times, bits (b*32+c)*6 +: 6 |
| busy_o | output | 1 | Frame readout in progress |
| byte_valid_o | output | 1 | byte_o carries a frame byte |
| frame_start_o | output | 1 | First byte of a frame |
| byte_o | output | 8 | Frame byte |

## Verification
Two things can fall in the same cycle: the last byte of a frame and a new trigger. The test provokes this by raising the trigger exactly while the 36th byte is on the output. The trigger must be dropped, so busy has to fall on the next cycle and no extra bytes may follow. The test also raises triggers in the middle of a frame and changes the hit inputs there. It then judges the stream against queued expected bytes and against the measured busy-run length.

// File: rtl/fhf_pkg.sv
package fhf_pkg;

    localparam int CODE_W = 2;
    localparam int DT_W   = 6;
    localparam int WORD_W = CODE_W + DT_W;

    localparam logic [CODE_W-1:0] CODE_NOHIT = 2'b11;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [DT_W-1:0]   dt;
    } chan_word_t;

    function automatic logic [1:0] eff_count(input logic [1:0] cfg);
        return (cfg == 2'd0) ? 2'd1 : cfg;
    endfunction

endpackage

// File: rtl/fhf_chan_enc.sv
module fhf_chan_enc
    import fhf_pkg::*;
#(
    parameter int NBX = 3
) (
    input  logic [NBX-1:0]      hits,
    input  logic [NBX*DT_W-1:0] drifts,
    input  logic [1:0]          nbx_eff,
    output chan_word_t          word
);

    always_comb begin
        word.code = CODE_NOHIT;
        word.dt   = '0;
        for (int b = NBX - 1; b >= 0; b--) begin
            if ((b < int'(nbx_eff)) && hits[b]) begin
                word.code = CODE_W'(b);
                word.dt   = drifts[b*DT_W +: DT_W];
            end
        end
    end

endmodule

// File: rtl/fhf_serializer.sv
module fhf_serializer #(
    parameter int FRAME_W   = 288,
    parameter int OUT_W     = 8,
    parameter int HDR_BEATS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               busy,
    output logic               first,
    output logic [OUT_W-1:0]   dout
);

    localparam int BEATS = FRAME_W / OUT_W;
    localparam int BW    = $clog2(BEATS);
    localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);
    localparam logic [BW-1:0] HDR_END   = BW'(HDR_BEATS);

    logic [FRAME_W-1:0] sreg;
    logic [BW-1:0]      beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            beat <= '0;
            sreg <= '0;
        end else if (!busy) begin
            if (trig) begin
                busy <= 1'b1;
                beat <= '0;
                sreg <= frame_in;
            end
        end else begin
            sreg <= sreg >> OUT_W;
            beat <= beat + 1'b1;
            if (beat == LAST_BEAT) begin
                busy <= 1'b0;
            end
        end
    end

    assign dout  = busy ? sreg[OUT_W-1:0] : '0;
    assign first = busy && (beat == '0);

    a_r6_frame_ends: assert property (@(posedge clk) disable iff (rst)
        busy && (beat == LAST_BEAT) |=> !busy);

    a_r6_start_needs_trig: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(trig));

    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy && trig && (beat != LAST_BEAT) |=> busy && (beat == $past(beat) + 1'b1));

    a_r4_nohit_zero_dt: assert property (@(posedge clk) disable iff (rst)
        busy && (beat >= HDR_END) && (dout[OUT_W-1 -: 2] == 2'b11) |-> (dout[OUT_W-3:0] == '0));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dout == '0));

endmodule

// File: rtl/fhf_formatter.sv
module fhf_formatter
    import fhf_pkg::*;
#(
    parameter int NCH   = 32,
    parameter int NBX   = 3,
    parameter int HDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      trig_i,
    input  logic [1:0]                nbx_cfg_i,
    input  logic [HDR_W-1:0]          header_i,
    input  logic [NBX*NCH-1:0]        hit_i,
    input  logic [NBX*NCH*DT_W-1:0]   drift_i,
    output logic                      busy_o,
    output logic                      byte_valid_o,
    output logic                      frame_start_o,
    output logic [WORD_W-1:0]         byte_o
);

    localparam int FRAME_W   = HDR_W + NCH * WORD_W;
    localparam int HDR_BEATS = HDR_W / WORD_W;

    logic [1:0]         nbx_eff;
    logic [FRAME_W-1:0] frame;
    chan_word_t         words [NCH];

    assign nbx_eff = eff_count(nbx_cfg_i);
    assign frame[HDR_W-1:0] = header_i;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [NBX-1:0]      ch_hits;
        logic [NBX*DT_W-1:0] ch_drift;
        for (genvar b = 0; b < NBX; b++) begin : g_bx
            assign ch_hits[b] = hit_i[b*NCH + c];
            assign ch_drift[b*DT_W +: DT_W] = drift_i[(b*NCH + c)*DT_W +: DT_W];
        end
        fhf_chan_enc #(.NBX(NBX)) u_enc (
            .hits    (ch_hits),
            .drifts  (ch_drift),
            .nbx_eff (nbx_eff),
            .word    (words[c])
        );
        assign frame[HDR_W + c*WORD_W +: WORD_W] = words[c];
    end

    fhf_serializer #(
        .FRAME_W   (FRAME_W),
        .OUT_W     (WORD_W),
        .HDR_BEATS (HDR_BEATS)
    ) u_ser (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig_i),
        .frame_in (frame),
        .busy     (busy_o),
        .first    (frame_start_o),
        .dout     (byte_o)
    );

    assign byte_valid_o = busy_o;

endmodule

// File: tb/sim_fhf_formatter.sv
module sim_fhf_formatter;

    localparam int NCH = 32;
    localparam int NBX = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0;
    logic [1:0] nbx = 2'd3;
    logic [31:0] hdr = '0;
    logic [NBX*NCH-1:0] hit_v;
    logic [NBX*NCH*6-1:0] dt_v;
    logic busy, valid, fstart;
    logic [7:0] dbyte;

    logic       hv [NBX][NCH];
    logic [5:0] dv [NBX][NCH];

    int n_tests = 0;
    int n_fail  = 0;
    int run_len = 0;
    bit done    = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    always_comb begin
        for (int b = 0; b < NBX; b++) begin
            for (int c = 0; c < NCH; c++) begin
                hit_v[b*NCH + c]       = hv[b][c];
                dt_v[(b*NCH + c)*6 +: 6] = dv[b][c];
            end
        end
    end

    fhf_formatter u0 (
        .clk           (clk),
        .rst           (rst),
        .trig_i        (trig),
        .nbx_cfg_i     (nbx),
        .header_i      (hdr),
        .hit_i         (hit_v),
        .drift_i       (dt_v),
        .busy_o        (busy),
        .byte_valid_o  (valid),
        .frame_start_o (fstart),
        .byte_o        (dbyte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic clear_inputs();
        for (int b = 0; b < NBX; b++)
            for (int c = 0; c < NCH; c++) begin
                hv[b][c] = 1'b0;
                dv[b][c] = 6'd0;
            end
    endtask

    task automatic randomize_inputs();
        for (int b = 0; b < NBX; b++)
            for (int c = 0; c < NCH; c++) begin
                hv[b][c] = 1'($urandom_range(0, 1));
                dv[b][c] = 6'($urandom);
            end
        hdr = $urandom;
    endtask

    // Expected bytes from R1..R5, queued before the trigger
    task automatic push_expected(input string tag);
        int n;
        n = (nbx == 2'd0) ? 1 : int'(nbx);
        for (int k = 0; k < 4; k++) begin
            exp_q.push_back(hdr[8*k +: 8]);
            tag_q.push_back({tag, " R1 header"});
        end
        for (int c = 0; c < NCH; c++) begin
            logic [1:0] code;
            logic [5:0] t;
            code = 2'b11;
            t    = 6'd0;
            for (int b = n - 1; b >= 0; b--) begin
                if (hv[b][c]) begin
                    code = 2'(b);
                    t    = dv[b][c];
                end
            end
            exp_q.push_back({code, t});
            tag_q.push_back({tag, " R2 channel byte"});
        end
    endtask

    task automatic send(input string tag);
        while (busy) @(negedge clk);
        push_expected(tag);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    // Monitor: scoreboard and busy-run length
    always @(negedge clk) begin
        if (!rst) begin
            if (valid) begin
                check("R6 frame_start", 32'(fstart), 32'(run_len == 0));
                if (exp_q.size() == 0) begin
                    check("R7 unexpected byte", 32'(dbyte), 32'hFFFF_FFFF);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, 32'(dbyte), 32'(e));
                end
            end else begin
                check("R8 idle byte zero", 32'(dbyte), 32'd0);
            end
            if (busy) begin
                run_len++;
            end else if (run_len != 0) begin
                check("R6 busy run length", 32'(run_len), 32'd36);
                run_len = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        repeat (3) @(negedge clk);
        check("R8 reset busy", 32'(busy), 32'd0);
        check("R8 reset valid", 32'(valid), 32'd0);
        check("R8 reset start", 32'(fstart), 32'd0);
        check("R8 reset byte", 32'(dbyte), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R4: empty event
        nbx = 2'd3;
        hdr = 32'hA5C3_1E07;
        send("R4 empty");

        // R3: every crossing hit, earliest kept
        for (int b = 0; b < NBX; b++)
            for (int c = 0; c < NCH; c++) begin
                hv[b][c] = 1'b1;
                dv[b][c] = 6'(c + 20*b);
            end
        hdr = 32'h0102_0304;
        send("R3 all crossings");

        // R3: hits only in later crossings
        clear_inputs();
        for (int c = 0; c < NCH; c++) begin
            hv[1 + (c % 2)][c] = 1'b1;
            dv[1 + (c % 2)][c] = 6'(63 - c);
        end
        send("R3 later crossing");

        // R5: limited crossing count ignores later ones
        nbx = 2'd1;
        send("R5 count1");
        nbx = 2'd2;
        send("R5 count2");
        nbx = 2'd0;
        send("R5 count0");

        // Random mixed frames
        for (int i = 0; i < 6; i++) begin
            randomize_inputs();
            nbx = 2'($urandom_range(0, 3));
            send("R3 random");
        end

        // R7: trigger and input change mid-frame
        randomize_inputs();
        nbx = 2'd3;
        send("R7 mid-frame");
        repeat (10) @(negedge clk);
        randomize_inputs();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;

        // R7: trigger during the last byte cycle
        while (busy) @(negedge clk);
        randomize_inputs();
        send("R7 last-beat");
        repeat (35) @(negedge clk);
        check("R7 last beat busy", 32'(busy), 32'd1);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        check("R7 dropped at last beat", 32'(busy), 32'd0);
        repeat (3) @(negedge clk);
        check("R7 still idle", 32'(busy), 32'd0);

        // Back to work after rejection
        randomize_inputs();
        send("R1 after reject");
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R1 all bytes seen", 32'(exp_q.size()), 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule